// File: doc/BRIEF.md
# Fiber Link Insert/Bypass Key Generator

This block plays the slow light patterns that a fiber-attached station sends to ask the ring to insert it or to bypass it. Each pattern is a fixed sequence of dark and lit intervals. Interval lengths are counted in periods of a watch-crystal reference tick of about 32.768 kHz, which arrives as a one-cycle strobe in the system clock domain. While a pattern plays, the block drives the optical transmitter enable on its own. At all other times the enable is taken from the normal data path input.

The insertion pattern has four intervals: a short dark interval, a long lit interval, a second short dark interval, and a final dark interval of about the long length. The bypass pattern is a single long lit interval. A request that arrives while a pattern is playing is kept and served after the current pattern ends. When both kinds are waiting, bypass goes first. A one-cycle done strobe marks the end of every pattern.

Top module: `keygen_top`

## Requirements
- R1: While rst_ni is low, and on its asynchronous assertion in the middle of a pattern, busy_o and done_o are 0, any waiting request is discarded, and led_en_o equals data_led_i.
- R2: Whenever busy_o is 0, led_en_o equals data_led_i in the same cycle.
- R3: The insertion pattern is, in order: dark for 28 ticks, lit for 56 ticks, dark for 28 ticks, dark for 53 ticks. That is 165 ticks in total, and led_en_o is 1 only during the 56-tick interval.
- R4: The bypass pattern is lit for 159 ticks.
- R5: If a request is sampled at a clock edge while no pattern is playing, that edge starts the pattern, and busy_o is 1 from the next cycle.
- R6: While busy_o is 1, led_en_o depends only on the interval being played and ignores data_led_i.
- R7: The pattern ends at the edge where its last tick is counted. In the following cycle done_o is 1 for exactly one cycle and busy_o is 0.
- R8: A request received during a pattern is held. It starts at the edge that closes the done cycle, so busy_o is low for exactly one cycle between the two patterns. A request sampled in the done cycle also starts at that edge.
- R9: If both kinds of request are waiting, or both arrive in the same idle cycle, the bypass pattern plays first and the insertion pattern plays after it.
- R10: Repeated requests of one kind that arrive while a pattern plays merge into a single pending pattern of that kind.
- R11: Ticks have no effect when no pattern is playing. A tick in the cycle in which a pattern starts is not counted, and a pattern ends only on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per reference-crystal period |
| ins_req_i | input | 1 | One-cycle request to play the insertion pattern |
| byp_req_i | input | 1 | One-cycle request to play the bypass pattern |
| data_led_i | input | 1 | Transmitter enable from the normal data path |
| led_en_o | output | 1 | Optical transmitter enable |
| busy_o | output | 1 | A pattern is playing |
| done_o | output | 1 | One-cycle strobe after a pattern ends |

## Verification
Two events can fall in the same cycle: a pattern finishing and a new request being granted. The bench provokes this in three ways. It queues bypass and insertion requests during an insertion pattern. It raises a request exactly in the done cycle. It raises both kinds of request in one idle cycle. Each case is judged on two points: busy_o must be low for exactly one cycle, and the first tick sample of the next pattern must show which kind was chosen. A scoreboard compares the led_en_o level sampled at each counted tick against the interval table. Random data_led_i values run throughout, so any leak from the data path shows up as a mismatch.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1A  = 3'd1,
    ST_K2   = 3'd2,
    ST_K1B  = 3'd3,
    ST_K3   = 3'd4,
    ST_BYP  = 3'd5
  } seg_e;
endpackage

// File: rtl/keygen_req_arb.sv
module keygen_req_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ins_req_i,
  input  logic byp_req_i,
  input  logic idle_i,
  output logic start_o,
  output logic start_byp_o
);
  logic ins_pend_q, byp_pend_q;
  logic ins_any, byp_any;

  assign ins_any     = ins_pend_q | ins_req_i;
  assign byp_any     = byp_pend_q | byp_req_i;
  assign start_o     = idle_i & (ins_any | byp_any);
  assign start_byp_o = byp_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_pend_q <= 1'b0;
      byp_pend_q <= 1'b0;
    end else begin
      // bypass wins a shared grant; the loser stays pending
      byp_pend_q <= byp_any & ~idle_i;
      ins_pend_q <= ins_any & ~(idle_i & ~byp_any);
    end
  end
endmodule

// File: rtl/keygen_seg_timer.sv
module keygen_seg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             seg_end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign seg_end_o = active_i & tick_i & (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!active_i || seg_end_o)  cnt_q <= '0;
    else if (tick_i)                  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/keygen_seq.sv
module keygen_seq
  import keygen_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int K1_TICKS  = 28,
  parameter int K2_TICKS  = 56,
  parameter int K3_TICKS  = 53,
  parameter int BYP_TICKS = 159
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_byp_i,
  input  logic             seg_end_i,
  output logic             active_o,
  output logic             lit_o,
  output logic [CNT_W-1:0] len_o,
  output logic             done_o
);
  seg_e state_q, state_d;
  logic done_q, last_seg;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = start_byp_i ? ST_BYP : ST_K1A;
      ST_K1A:  if (seg_end_i) state_d = ST_K2;
      ST_K2:   if (seg_end_i) state_d = ST_K1B;
      ST_K1B:  if (seg_end_i) state_d = ST_K3;
      ST_K3:   if (seg_end_i) state_d = ST_IDLE;
      ST_BYP:  if (seg_end_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_K2:   len_o = CNT_W'(K2_TICKS);
      ST_K3:   len_o = CNT_W'(K3_TICKS);
      ST_BYP:  len_o = CNT_W'(BYP_TICKS);
      default: len_o = CNT_W'(K1_TICKS);
    endcase
  end

  assign last_seg = (state_q == ST_K3) || (state_q == ST_BYP);
  assign active_o = (state_q != ST_IDLE);
  assign lit_o    = (state_q == ST_K2) || (state_q == ST_BYP);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= seg_end_i & last_seg;
    end
  end
endmodule

// File: rtl/keygen_top.sv
module keygen_top #(
  parameter int K1_TICKS  = 28,
  parameter int K2_TICKS  = 56,
  parameter int K3_TICKS  = 53,
  parameter int BYP_TICKS = 159
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ins_req_i,
  input  logic byp_req_i,
  input  logic data_led_i,
  output logic led_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_A    = (K1_TICKS > K2_TICKS) ? K1_TICKS : K2_TICKS;
  localparam int MAX_B    = (K3_TICKS > BYP_TICKS) ? K3_TICKS : BYP_TICKS;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic start, start_byp, seg_end, active, lit;
  logic [CNT_W-1:0] len;

  keygen_req_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ins_req_i   (ins_req_i),
    .byp_req_i   (byp_req_i),
    .idle_i      (~active),
    .start_o     (start),
    .start_byp_o (start_byp)
  );

  keygen_seq #(
    .CNT_W     (CNT_W),
    .K1_TICKS  (K1_TICKS),
    .K2_TICKS  (K2_TICKS),
    .K3_TICKS  (K3_TICKS),
    .BYP_TICKS (BYP_TICKS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_byp_i (start_byp),
    .seg_end_i   (seg_end),
    .active_o    (active),
    .lit_o       (lit),
    .len_o       (len),
    .done_o      (done_o)
  );

  keygen_seg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .tick_i    (tick_i),
    .len_i     (len),
    .seg_end_o (seg_end)
  );

  assign busy_o   = active;
  assign led_en_o = active ? lit : data_led_i;
endmodule

// File: rtl/keygen_chk.sv
module keygen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic ins_req_i,
  input logic byp_req_i,
  input logic data_led_i,
  input logic led_en_o,
  input logic busy_o,
  input logic done_o
);
  // R7
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  busy_fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  req_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (ins_req_i || byp_req_i)) |=> busy_o);

  // R2
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (led_en_o == data_led_i));

  // R11
  end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> busy_o);
endmodule

bind keygen_top keygen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .ins_req_i  (ins_req_i),
  .byp_req_i  (byp_req_i),
  .data_led_i (data_led_i),
  .led_en_o   (led_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_keygen_top.sv
module tb_keygen_top;
  localparam int K1 = 28, K2 = 56, K3 = 53, KB = 159, TICK_DIV = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic ins_req_i = 1'b0, byp_req_i = 1'b0, data_led_i = 1'b0;
  logic led_en_o, busy_o, done_o;

  int n_tests = 0, n_fail = 0, mism = 0, bad = 0;
  bit exp_q[$];
  bit got_q[$];
  bit cur_byp;

  keygen_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .ins_req_i(ins_req_i), .byp_req_i(byp_req_i), .data_led_i(data_led_i),
    .led_en_o(led_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic bit exp_level(bit byp, int i);
    if (byp) return 1'b1;
    return (i >= K1) && (i < K1 + K2);
  endfunction

  function automatic int exp_len(bit byp);
    return byp ? KB : 2 * K1 + K2 + K3;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // tick strobe and random data-path level
  initial begin
    int c = 0;
    forever begin
      @(posedge clk_i); #1;
      tick_i     = (c == TICK_DIV - 1);
      c          = (c + 1) % TICK_DIV;
      data_led_i = 1'($urandom_range(0, 1));
    end
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      got_q.delete();
    end else begin
      if (busy_o && tick_i) got_q.push_back(led_en_o);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          cur_byp = exp_q.pop_front();
          mism = 0;
          foreach (got_q[i]) if (got_q[i] != exp_level(cur_byp, i)) mism++;
          chk(got_q.size() == exp_len(cur_byp), cur_byp ? "R4 key length" : "R3 key length",
              got_q.size(), exp_len(cur_byp));
          chk(mism == 0, cur_byp ? "R4/R6 lit pattern" : "R3/R6 segment pattern", mism, 0);
          chk(!busy_o, "R7 busy low in done cycle", int'(busy_o), 0);
        end
        got_q.delete();
      end
    end
  end

  task automatic send(bit byp, bit push);
    if (push) exp_q.push_back(byp);
    @(posedge clk_i); #1;
    if (byp) byp_req_i = 1'b1; else ins_req_i = 1'b1;
    @(posedge clk_i); #1;
    byp_req_i = 1'b0; ins_req_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  task automatic wait_busy_tick();
    do @(negedge clk_i); while (!(busy_o && tick_i));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (5) @(negedge clk_i);
    chk(!busy_o, "R1 busy in reset", int'(busy_o), 0);
    chk(!done_o, "R1 done in reset", int'(done_o), 0);
    chk(led_en_o == data_led_i, "R1 led follows data in reset", int'(led_en_o), int'(data_led_i));
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // R2 / R11 idle with ticks
    bad = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (busy_o || done_o || led_en_o != data_led_i) bad++;
    end
    chk(bad == 0, "R2/R11 idle follow with ticks", bad, 0);

    // R3 insertion
    send(1'b0, 1'b1);
    @(negedge clk_i);
    chk(busy_o, "R5 busy after insert request", int'(busy_o), 1);
    wait_done();
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R7 single done pulse", int'(done_o), 0);

    // R4 bypass
    send(1'b1, 1'b1);
    @(negedge clk_i);
    chk(busy_o, "R5 busy after bypass request", int'(busy_o), 1);
    wait_done();

    // R8 / R9 / R10 held and merged requests
    send(1'b0, 1'b1);
    repeat (100) @(posedge clk_i);
    send(1'b1, 1'b0);
    send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    wait_done();
    @(negedge clk_i);
    chk(busy_o, "R8 held request starts after done", int'(busy_o), 1);
    wait_busy_tick();
    chk(led_en_o, "R9 pending bypass served first", int'(led_en_o), 1);
    wait_done();
    wait_done();
    bad = 0;
    repeat (1500) begin
      @(negedge clk_i);
      if (busy_o) bad++;
    end
    chk(bad == 0, "R10 merged requests play once", bad, 0);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    // R9 simultaneous requests in idle
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    @(posedge clk_i); #1;
    ins_req_i = 1'b1; byp_req_i = 1'b1;
    @(posedge clk_i); #1;
    ins_req_i = 1'b0; byp_req_i = 1'b0;
    wait_busy_tick();
    chk(led_en_o, "R9 simultaneous requests bypass first", int'(led_en_o), 1);
    wait_done();
    wait_done();

    // R8 request exactly in the done cycle
    send(1'b0, 1'b1);
    exp_q.push_back(1'b0);
    wait_done();
    ins_req_i = 1'b1;
    @(posedge clk_i); #1 ins_req_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o, "R8 request in done cycle starts at once", int'(busy_o), 1);
    wait_done();

    // R1 abort mid key, pending discarded
    send(1'b1, 1'b0);
    repeat (300) @(posedge clk_i);
    send(1'b0, 1'b0);
    @(posedge clk_i); #1 rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 reset aborts key", int'(busy_o), 0);
    chk(led_en_o == data_led_i, "R1 led follows data after abort", int'(led_en_o), int'(data_led_i));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    bad = 0;
    repeat (2500) begin
      @(negedge clk_i);
      if (busy_o || done_o) bad++;
    end
    chk(bad == 0, "R1 pending cleared by reset", bad, 0);
    chk(exp_q.size() == 0, "R7 all expected keys completed", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule